// File: doc/BRIEF.md
# Word-to-Byte Register Bridge

This block gives a management processor a 32-bit bus path into a small bank of 8-bit housekeeping registers. The processor issues Wishbone classic-cycle reads and writes. The bridge answers only when the address falls inside its window. It splits each word into four byte-register visits in ascending address order. On a read it gathers the four bytes into one word. On a write it sends each selected byte to its register. The bus cycle is held without acknowledge until the last byte has been handled.

A second port, one byte wide, lets a serial front-door controller read and write the same registers one byte at a time. That port always wins the bank. When it is busy, the word sequencer pauses on its current byte.

Top module: `hk_byte_bridge`

## Requirements
- R1: Only bus addresses whose bits above WIN_BITS equal those of BASE_ADDR (default 0x26000000) are served. Any other access is never acknowledged and changes no register.
- R2: The bank holds REG_COUNT registers of 8 bits at byte offsets 0 to REG_COUNT-1. Register i comes out of reset as RST_BASE + i.
- R3: Byte order is little-endian. The byte at word offset + k occupies data bits [8k+7:8k], and the word at offset 0 reads as {reg3, reg2, reg1, reg0}.
- R4: With no front-door traffic, ack rises on the fifth clock after the cycle in which cyc and stb were accepted. Ack stays high for exactly one cycle and is low while the bytes are being processed.
- R5: On a write, a byte whose sel bit is 1 updates its register. A byte whose sel bit is 0 leaves its register unchanged.
- R6: A byte offset at or above REG_COUNT reads as 0x00, and writes to it are discarded.
- R7: When fd_req_i is high, fd_we_i=1 writes fd_wdata_i into the register at fd_addr_i. On the next cycle fd_rdata_o shows what that register held before the write. fd_rdata_o holds its value when there is no request.
- R8: Every cycle that fd_req_i is high during a word access stalls the sequencer on its current byte, which delays ack by one cycle.
- R9: A word access starts only when cyc and stb are both high. The bridge does not start again during the cycle in which it drives ack.
- R10: Synchronous active-high reset clears ack, returns the sequencer to idle, zeroes fd_rdata_o and wb_dat_o, and reloads every register with its default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Bus write enable |
| wb_adr_i | input | 32 | Bus byte address |
| wb_dat_i | input | 32 | Bus write data |
| wb_sel_i | input | 4 | Bus byte selects |
| wb_ack_o | output | 1 | Bus acknowledge, one-cycle pulse |
| wb_dat_o | output | 32 | Bus read data, valid with ack |
| fd_req_i | input | 1 | Front-door byte request |
| fd_we_i | input | 1 | Front-door write enable |
| fd_addr_i | input | WIN_BITS | Front-door byte offset |
| fd_wdata_i | input | 8 | Front-door write byte |
| fd_rdata_o | output | 8 | Front-door read byte |

## Verification
The bench builds the bridge with WIN_BITS=6 and REG_COUNT=6. This makes the bank size something other than a power of two and puts the end of the bank in the middle of the second word, so one access mixes real registers (offsets 4 and 5) with empty ones (offsets 6 and 7). The small window also makes a neighbouring out-of-window address easy to reach. Front-door pulses that overlap a running word access exercise the stall path and the longer acknowledge delay.

// File: rtl/hk_byte_bridge.sv
`timescale 1ns/1ps
module hk_byte_bridge #(
  parameter logic [31:0] BASE_ADDR = 32'h2600_0000,
  parameter int          WIN_BITS  = 8,
  parameter int          REG_COUNT = 8,
  parameter logic [7:0]  RST_BASE  = 8'hA0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wb_cyc_i,
  input  logic                wb_stb_i,
  input  logic                wb_we_i,
  input  logic [31:0]         wb_adr_i,
  input  logic [31:0]         wb_dat_i,
  input  logic [3:0]          wb_sel_i,
  output logic                wb_ack_o,
  output logic [31:0]         wb_dat_o,
  input  logic                fd_req_i,
  input  logic                fd_we_i,
  input  logic [WIN_BITS-1:0] fd_addr_i,
  input  logic [7:0]          fd_wdata_i,
  output logic [7:0]          fd_rdata_o
);
  localparam int AW = WIN_BITS;
  localparam int IW = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic [7:0]  bank [REG_COUNT];
  logic        busy;
  logic [1:0]  idx;
  logic [31:0] gather;

  wire          hit      = (wb_adr_i[31:AW] == BASE_ADDR[31:AW]);
  wire          step     = busy && !fd_req_i;
  wire [AW-1:0] wb_baddr = {wb_adr_i[AW-1:2], idx};
  wire          wb_map   = (wb_baddr < AW'(REG_COUNT));
  wire          fd_map   = (fd_addr_i < AW'(REG_COUNT));
  wire [7:0]    wb_rbyte = wb_map ? bank[wb_baddr[IW-1:0]] : 8'h00;
  wire [7:0]    fd_rbyte = fd_map ? bank[fd_addr_i[IW-1:0]] : 8'h00;
  wire [7:0]    wb_wbyte = wb_dat_i[{idx, 3'b000} +: 8];

  assign wb_dat_o = gather;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) bank[i] <= RST_BASE + 8'(i);
    end else if (fd_req_i && fd_we_i && fd_map) begin
      bank[fd_addr_i[IW-1:0]] <= fd_wdata_i;
    end else if (step && wb_we_i && wb_sel_i[idx] && wb_map) begin
      bank[wb_baddr[IW-1:0]] <= wb_wbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      idx      <= 2'd0;
      wb_ack_o <= 1'b0;
      gather   <= 32'h0;
    end else begin
      wb_ack_o <= step && (idx == 2'd3);
      if (!busy) begin
        if (wb_cyc_i && wb_stb_i && hit && !wb_ack_o) begin
          busy <= 1'b1;
          idx  <= 2'd0;
        end
      end else if (step) begin
        gather[{idx, 3'b000} +: 8] <= wb_rbyte;
        idx <= idx + 2'd1;
        if (idx == 2'd3) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           fd_rdata_o <= 8'h00;
    else if (fd_req_i) fd_rdata_o <= fd_rbyte;
  end

  a_r4_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |=> !wb_ack_o);
  a_r4_ack_after_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_ack_o) |-> $past(busy));
  a_r1_outside_ignored: assert property (@(posedge clk) disable iff (rst)
    (!busy && wb_cyc_i && wb_stb_i && !hit) |=> (!busy && !wb_ack_o));
  a_r8_fd_stall: assert property (@(posedge clk) disable iff (rst)
    (busy && fd_req_i) |=> (busy && $stable(idx) && !wb_ack_o));
  a_r9_needs_cyc_stb: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(wb_cyc_i && wb_stb_i)) |=> !busy);
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |=> !busy);
endmodule

// File: tb/hk_byte_bridge_test.sv
`timescale 1ns/1ps
module hk_byte_bridge_test;
  localparam logic [31:0] BASE = 32'h2600_0000;
  localparam int WB = 6;
  localparam int NR = 6;

  logic clk = 0, rst = 1;
  logic cyc = 0, stb = 0, we = 0;
  logic [31:0] adr = 0, dat = 0;
  logic [3:0] sel = 0;
  logic fd_req = 0, fd_we = 0;
  logic [WB-1:0] fd_addr = 0;
  logic [7:0] fd_wdata = 0;
  logic wb_ack_o;
  logic [31:0] wb_dat_o;
  logic [7:0] fd_rdata_o;

  hk_byte_bridge #(.BASE_ADDR(BASE), .WIN_BITS(WB), .REG_COUNT(NR), .RST_BASE(8'h30)) uut (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(dat), .wb_sel_i(sel), .wb_ack_o(wb_ack_o),
    .wb_dat_o(wb_dat_o), .fd_req_i(fd_req), .fd_we_i(fd_we), .fd_addr_i(fd_addr),
    .fd_wdata_i(fd_wdata), .fd_rdata_o(fd_rdata_o));

  always #2 clk = ~clk;

  int nvec = 0, nfail = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [7:0] mb [8];
  bit m_busy = 0, exp_ack = 0, m_we = 0;
  int k = 0;
  logic [31:0] exp_word = 0;
  logic [7:0] exp_fd = 0;

  function automatic logic [7:0] mrd(input int a);
    return (a < NR) ? mb[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) mb[i] = 8'h30 + 8'(i);
      m_busy = 0; exp_ack = 0; k = 0; exp_fd = 0; exp_word = 0;
    end else begin
      bit was_ack;
      was_ack = exp_ack;
      exp_ack = 0;
      if (fd_req) begin
        exp_fd = mrd(int'(fd_addr));
        if (fd_we && fd_addr < NR) mb[fd_addr] = fd_wdata;
      end
      if (m_busy) begin
        if (!fd_req) begin
          int a;
          a = int'(adr[WB-1:2]) * 4 + k;
          if (we) begin
            if (sel[k] && a < NR) mb[a] = dat[8*k +: 8];
          end else exp_word[8*k +: 8] = mrd(a);
          k++;
          if (k == 4) begin m_busy = 0; exp_ack = 1; m_we = we; end
        end
      end else if (!was_ack && cyc && stb && adr[31:WB] == BASE[31:WB]) begin
        m_busy = 1; k = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R4 ack", {31'b0, wb_ack_o}, {31'b0, exp_ack});
      if (exp_ack && !m_we) check("R3 data", wb_dat_o, exp_word);
      check("R7 fd", {24'b0, fd_rdata_o}, {24'b0, exp_fd});
    end
  end

  task automatic wb_access(input logic [31:0] a, input logic w, input logic [31:0] d,
                           input logic [3:0] s, output logic [31:0] rd, output int lat);
    @(negedge clk);
    adr = a; we = w; dat = d; sel = s; cyc = 1; stb = 1; lat = 0;
    do begin @(negedge clk); lat++; end while (!wb_ack_o && lat < 50);
    rd = wb_dat_o; cyc = 0; stb = 0; we = 0;
  endtask

  task automatic fd_access(input logic w, input logic [WB-1:0] a, input logic [7:0] d,
                           output logic [7:0] rd);
    @(negedge clk);
    fd_req = 1; fd_we = w; fd_addr = a; fd_wdata = d;
    @(negedge clk);
    rd = fd_rdata_o; fd_req = 0; fd_we = 0;
  endtask

  task automatic hold_req(input logic c, input logic s, input logic [31:0] a, output int acks);
    @(negedge clk);
    adr = a; we = 1; dat = 32'hFFFF_FFFF; sel = 4'hF; cyc = c; stb = s; acks = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (wb_ack_o) acks++; end
    cyc = 0; stb = 0; we = 0;
  endtask

  initial begin
    #(4 * 200000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] rw;
    logic [7:0] rb;
    int lat, acks;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < NR; i++) begin
      fd_access(0, WB'(i), 8'h00, rb);
      check("R2 default", {24'b0, rb}, 32'h30 + i);
    end
    wb_access(BASE, 0, 0, 4'h0, rw, lat);
    check("R3 little-endian", rw, 32'h3332_3130);
    check("R4 latency", lat, 5);
    wb_access(BASE + 4, 0, 0, 4'h0, rw, lat);
    check("R6 partial", rw, 32'h0000_3534);
    wb_access(BASE + 8, 0, 0, 4'h0, rw, lat);
    check("R6 empty word", rw, 32'h0);
    wb_access(BASE, 1, 32'hDDCC_BBAA, 4'hF, rw, lat);
    wb_access(BASE, 1, 32'h1122_3344, 4'b0101, rw, lat);
    wb_access(BASE, 0, 0, 4'h0, rw, lat);
    check("R5 sel mask", rw, 32'hDD22_BB44);
    wb_access(BASE + 4, 1, 32'h9988_7766, 4'hF, rw, lat);
    wb_access(BASE + 4, 0, 0, 4'h0, rw, lat);
    check("R6 discard", rw, 32'h0000_7766);
    fd_access(1, 6'd2, 8'h5A, rb);
    check("R7 old value", {24'b0, rb}, 32'h22);
    wb_access(BASE, 0, 0, 4'h0, rw, lat);
    check("R7 write seen", rw, 32'hDD5A_BB44);
    fork
      wb_access(BASE, 0, 0, 4'h0, rw, lat);
      begin
        @(negedge clk); @(negedge clk);
        fd_req = 1; fd_addr = 6'd5;
        @(negedge clk);
        @(negedge clk);
        fd_req = 0;
      end
    join
    check("R8 stall latency", lat, 7);
    check("R8 data", rw, 32'hDD5A_BB44);
    hold_req(1, 1, 32'h2700_0000, acks);
    check("R1 no ack", acks, 0);
    hold_req(1, 1, BASE + 32'h40, acks);
    check("R1 no ack near", acks, 0);
    hold_req(1, 0, BASE, acks);
    check("R9 cyc only", acks, 0);
    hold_req(0, 1, BASE, acks);
    check("R9 stb only", acks, 0);
    wb_access(BASE, 0, 0, 4'h0, rw, lat);
    check("R1 unchanged", rw, 32'hDD5A_BB44);
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    check("R10 ack low", {31'b0, wb_ack_o}, 32'h0);
    check("R10 fd clear", {24'b0, fd_rdata_o}, 32'h0);
    rst = 0;
    fd_access(0, 6'd3, 8'h00, rb);
    check("R10 default", {24'b0, rb}, 32'h33);
    wb_access(BASE + 4, 0, 0, 4'h0, rw, lat);
    check("R10 reload", rw, 32'h0000_3534);
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule